// File: doc/BRIEF.md
# Synchronized Clock Stop Controller

This block sits between the clock synthesizers and the board-level clock drivers. It takes one CPU-rate clock and one PCI-rate clock that are already generated and in phase with each other. It fans them out to a parameterized number of CPU outputs, a parameterized number of stoppable PCI outputs and one free-running PCI output. Three active-low control pins change asynchronously: a CPU stop, a PCI stop and a power-down. Each pin passes through a two-flop synchronizer clocked by the reference PCI clock. Every output then passes through its own gate, and that gate's enable only changes on the falling edge of the clock it gates. As a result a stopped output always ends on a complete high phase and a restarted output always begins with one.

A small power state machine has three states. **PS_OFF** is entered at reset and on power-down. In this state every output is held low and the oscillator-off flag is raised. **PS_SETTLE** counts `SETTLE_CYC` reference clock cycles, standing in for oscillator and PLL start-up, and keeps the outputs low. **PS_ON** lets the stop inputs decide the gates. The transitions are:
- *wake*: PS_OFF to PS_SETTLE, when the synchronized power-down input reads high.
- *settled*: PS_SETTLE to PS_ON, when the counter reaches its last value.
- *drop*: PS_SETTLE or PS_ON to PS_OFF, when the synchronized power-down input reads low.

The default `SETTLE_CYC` is about 3 ms of a 33 MHz reference.

Top module: `clkstop_ctrl`

## Requirements
- R1: While `rst_n` is low, every clock output is low and `osc_off` is high.
- R2: A power-down input that rises to high (inactive) while in PS_OFF or during reset release starts the settle count. Count the reference rising edges after the change as 1, 2, 3 and so on. The free-running output is low through edge SETTLE_CYC+3 and pulses from edge SETTLE_CYC+4 on. `osc_off` drops after edge 3.
- R3: CPU stop is active low. Once it is low, all CPU outputs are held low, while the PCI outputs and the free-running output keep toggling. The first suppressed CPU pulse is the first CPU rising edge that follows the first CPU falling edge after reference edge 2.
- R4: PCI stop is active low. Once it is low, all stoppable PCI outputs are held low, starting with the pulse at reference edge 3. The pulse at edge 2 still appears.
- R5: When a stop input returns high, the affected outputs restart with the same latency as in R3 and R4, counted from that change.
- R6: A power-down input that goes low drives every output low, the free-running one included. The stoppable PCI outputs and the free-running output are suppressed from reference edge 4. The CPU outputs are suppressed from the first CPU rising edge after the first CPU falling edge that follows edge 3. `osc_off` rises after edge 3.
- R7: Every output high pulse is a full high phase of its source clock. No runt pulse occurs, however close to a clock edge a control input changes.
- R8: The free-running PCI output ignores PCI stop. It toggles in PS_ON whatever the level of PCI stop, including right after a wake with PCI stop held low.
- R9: The two stop inputs act independently. Changing one, or both in the same cycle, affects only its own group with the latencies of R3 to R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk_in | input | 1 | CPU-rate source clock, rising edges aligned with the PCI source |
| pci_clk_in | input | 1 | PCI-rate reference clock, never stopped, clocks the synchronizers and the state machine |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_stop_n | input | 1 | Asynchronous CPU group stop, active low |
| pci_stop_n | input | 1 | Asynchronous PCI group stop, active low |
| pwr_dn_n | input | 1 | Asynchronous power-down, active low |
| cpu_clk_out | output | N_CPU | Gated CPU clocks |
| pci_clk_out | output | N_PCI | Gated stoppable PCI clocks |
| pci_free_out | output | 1 | Free-running PCI clock, gated only by power state |
| osc_off | output | 1 | High while the oscillator and PLLs are modelled as off (PS_OFF) |

## Verification
The hardest condition to reach is a control input that changes within a nanosecond or two of a clock edge. At that point a gate that switched at the wrong phase would clip a pulse. The stimulus therefore places each random stop toggle at a random offset inside the low phase of the reference clock. A monitor samples every output on a fine grid and measures each high pulse. The second hard case is a wake from power-down with PCI stop already held low. It is reached by asserting PCI stop inside PS_OFF, before the wake.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
    // Power sequencing states of the clock stop controller
    typedef enum logic [1:0] {
        PS_OFF    = 2'd0,
        PS_SETTLE = 2'd1,
        PS_ON     = 2'd2
    } pwr_state_t;
endpackage

// File: rtl/clkstop_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous level inputs.
// All stages reset to zero, which reads as "stop / power down".
module clkstop_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= d_async;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q_sync = stg_q[STAGES-1];
endmodule

// File: rtl/clkstop_gate.sv
// Bank of glitch-free clock gates. Each enable is sampled on the falling
// edge of the gated clock, so it only changes while that clock is low.
module clkstop_gate #(
    parameter int W = 1
) (
    input  logic         clk_in,
    input  logic         rst_n,
    input  logic         run_req,
    output logic [W-1:0] clk_out
);
    for (genvar g = 0; g < W; g++) begin : g_gate
        logic en_q;
        always_ff @(negedge clk_in or negedge rst_n) begin
            if (!rst_n) en_q <= 1'b0;
            else        en_q <= run_req;
        end
        assign clk_out[g] = clk_in & en_q;
    end
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
    import clkstop_pkg::*;
#(
    parameter int N_CPU       = 4,
    parameter int N_PCI       = 7,
    parameter int SETTLE_CYC  = 100000,
    parameter int SYNC_STAGES = 2
) (
    input  logic             cpu_clk_in,
    input  logic             pci_clk_in,
    input  logic             rst_n,
    input  logic             cpu_stop_n,
    input  logic             pci_stop_n,
    input  logic             pwr_dn_n,
    output logic [N_CPU-1:0] cpu_clk_out,
    output logic [N_PCI-1:0] pci_clk_out,
    output logic             pci_free_out,
    output logic             osc_off
);
    localparam int          CW       = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(SETTLE_CYC - 1);

    // ---------------- control synchronization ----------------
    logic [2:0] ctl_s;
    logic       cpu_go_s, pci_go_s, pwr_ok_s;

    clkstop_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (pci_clk_in),
        .rst_n   (rst_n),
        .d_async ({pwr_dn_n, pci_stop_n, cpu_stop_n}),
        .q_sync  (ctl_s)
    );

    assign cpu_go_s = ctl_s[0];
    assign pci_go_s = ctl_s[1];
    assign pwr_ok_s = ctl_s[2];

    // ---------------- power state machine ----------------
    pwr_state_t    state_q, state_nxt;
    logic [CW-1:0] cnt_q;
    logic          run;

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            PS_OFF:    if (pwr_ok_s)              state_nxt = PS_SETTLE;
            PS_SETTLE: if (!pwr_ok_s)             state_nxt = PS_OFF;
                       else if (cnt_q == CNT_LAST) state_nxt = PS_ON;
            PS_ON:     if (!pwr_ok_s)             state_nxt = PS_OFF;
            default:                              state_nxt = PS_OFF;
        endcase
    end

    // state register and settle counter
    always_ff @(posedge pci_clk_in or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_nxt;
            if (state_q == PS_SETTLE) cnt_q <= cnt_q + 1'b1;
            else                      cnt_q <= '0;
        end
    end

    // state decoded outputs
    always_comb begin
        run     = 1'b0;
        osc_off = 1'b0;
        unique case (state_q)
            PS_OFF:    osc_off = 1'b1;
            PS_SETTLE: run     = 1'b0;
            PS_ON:     run     = 1'b1;
            default:   osc_off = 1'b1;
        endcase
    end

    // ---------------- output gates ----------------
    logic free_vec;

    clkstop_gate #(.W(N_CPU)) u_cpu_gate (
        .clk_in  (cpu_clk_in),
        .rst_n   (rst_n),
        .run_req (run & cpu_go_s),
        .clk_out (cpu_clk_out)
    );

    clkstop_gate #(.W(N_PCI)) u_pci_gate (
        .clk_in  (pci_clk_in),
        .rst_n   (rst_n),
        .run_req (run & pci_go_s),
        .clk_out (pci_clk_out)
    );

    clkstop_gate #(.W(1)) u_free_gate (
        .clk_in  (pci_clk_in),
        .rst_n   (rst_n),
        .run_req (run),
        .clk_out (free_vec)
    );

    assign pci_free_out = free_vec;
endmodule

// File: rtl/clkstop_ctrl_chk.sv
module clkstop_ctrl_chk #(
    parameter int            N_CPU    = 4,
    parameter int            N_PCI    = 7,
    parameter int            CW       = 1,
    parameter logic [CW-1:0] CNT_LAST = '0
) (
    input logic             cpu_clk_in,
    input logic             pci_clk_in,
    input logic             rst_n,
    input logic [N_CPU-1:0] cpu_clk_out,
    input logic [N_PCI-1:0] pci_clk_out,
    input logic             pci_free_out,
    input logic             osc_off,
    input logic             run,
    input logic             cpu_go_s,
    input logic             pci_go_s,
    input logic [CW-1:0]    cnt_q
);
    // R3: a synchronized CPU stop blanks the CPU group from the next high phase
    a_r3_cpu_held_low: assert property (@(negedge cpu_clk_in) disable iff (!rst_n)
        !cpu_go_s |=> (cpu_clk_out == '0));

    // R4: a synchronized PCI stop blanks the stoppable PCI group
    a_r4_pci_held_low: assert property (@(negedge pci_clk_in) disable iff (!rst_n)
        !pci_go_s |=> (pci_clk_out == '0));

    // R6: power state off silences every PCI-rate output
    a_r6_off_all_low: assert property (@(negedge pci_clk_in) disable iff (!rst_n)
        osc_off |=> (!pci_free_out && pci_clk_out == '0));

    // R8: in the running state the free output pulses regardless of PCI stop
    a_r8_free_toggles: assert property (@(negedge pci_clk_in) disable iff (!rst_n)
        run |=> pci_free_out);

    // R2: running is only reached after the full settle count
    a_r2_settle_done: assert property (@(posedge pci_clk_in) disable iff (!rst_n)
        $rose(run) |-> ($past(cnt_q) == CNT_LAST));
endmodule

bind clkstop_ctrl clkstop_ctrl_chk #(
    .N_CPU(N_CPU), .N_PCI(N_PCI), .CW(CW), .CNT_LAST(CNT_LAST)
) u_chk (
    .cpu_clk_in   (cpu_clk_in),
    .pci_clk_in   (pci_clk_in),
    .rst_n        (rst_n),
    .cpu_clk_out  (cpu_clk_out),
    .pci_clk_out  (pci_clk_out),
    .pci_free_out (pci_free_out),
    .osc_off      (osc_off),
    .run          (run),
    .cpu_go_s     (cpu_go_s),
    .pci_go_s     (pci_go_s),
    .cnt_q        (cnt_q)
);

// File: tb/clkstop_ctrl_tb.sv
`timescale 1ns/100ps
module clkstop_ctrl_tb;
    localparam int N_CPU = 4;
    localparam int N_PCI = 7;
    localparam int S     = 16;

    logic cpu_clk = 1'b1;
    logic pci_clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_stop_n = 1'b1, pci_stop_n = 1'b1, pwr_dn_n = 1'b1;
    logic [N_CPU-1:0] cpu_clk_out;
    logic [N_PCI-1:0] pci_clk_out;
    logic pci_free_out, osc_off;

    int n_chk = 0, n_err = 0;
    int runts = 0, pulses = 0;

    // 50 MHz reference, CPU clock at twice the rate with aligned rising edges
    always #10 pci_clk = ~pci_clk;
    always #5  cpu_clk = ~cpu_clk;

    clkstop_ctrl #(.N_CPU(N_CPU), .N_PCI(N_PCI), .SETTLE_CYC(S)) u_dut (
        .cpu_clk_in(cpu_clk), .pci_clk_in(pci_clk), .rst_n(rst_n),
        .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .pwr_dn_n(pwr_dn_n),
        .cpu_clk_out(cpu_clk_out), .pci_clk_out(pci_clk_out),
        .pci_free_out(pci_free_out), .osc_off(osc_off));

    // Pulse width monitor (R7): every high pulse must be a full high phase
    int hl_cpu [N_CPU];
    int hl_pci [N_PCI];
    int hl_free;
    initial begin
        for (int i = 0; i < N_CPU; i++) hl_cpu[i] = 0;
        for (int i = 0; i < N_PCI; i++) hl_pci[i] = 0;
        hl_free = 0;
        #0.5;
        forever begin
            for (int i = 0; i < N_CPU; i++) begin
                if (cpu_clk_out[i]) hl_cpu[i]++;
                else begin
                    if (hl_cpu[i] != 0) begin pulses++; if (hl_cpu[i] != 5) runts++; end
                    hl_cpu[i] = 0;
                end
            end
            for (int i = 0; i < N_PCI; i++) begin
                if (pci_clk_out[i]) hl_pci[i]++;
                else begin
                    if (hl_pci[i] != 0) begin pulses++; if (hl_pci[i] != 10) runts++; end
                    hl_pci[i] = 0;
                end
            end
            if (pci_free_out) hl_free++;
            else begin
                if (hl_free != 0) begin pulses++; if (hl_free != 10) runts++; end
                hl_free = 0;
            end
            #1;
        end
    end

    logic [N_PCI-1:0] s_pci;
    logic [N_CPU-1:0] s_cpu_a, s_cpu_b;
    logic s_free, s_osc;

    // Sample one reference cycle: 3 ns after its rising edge (PCI and CPU pulse
    // starting there) and 13 ns after it (CPU pulse starting mid-cycle).
    task automatic step();
        @(posedge pci_clk);
        #3;
        s_pci = pci_clk_out; s_free = pci_free_out; s_cpu_a = cpu_clk_out; s_osc = osc_off;
        #10;
        s_cpu_b = cpu_clk_out;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] cvec(bit on);
        return on ? 32'((1 << N_CPU) - 1) : 32'd0;
    endfunction
    function automatic logic [31:0] pvec(bit on);
        return on ? 32'((1 << N_PCI) - 1) : 32'd0;
    endfunction

    // Change controls at a random point inside the low phase of the reference
    task automatic drive(bit c, bit p, bit w);
        @(negedge pci_clk);
        #(1 + ($urandom % 8));
        cpu_stop_n = c; pci_stop_n = p; pwr_dn_n = w;
    endtask

    // Stop-input change with power running: R3/R4/R5/R8/R9 latencies
    task automatic stop_change(bit oc, bit nc, bit op, bit np, string tag);
        drive(nc, np, 1'b1);
        for (int k = 1; k <= 4; k++) begin
            step();
            chk({tag, " pci group"}, 32'(s_pci), pvec(k >= 3 ? np : op));
            chk("R8 free ignores pci stop", 32'(s_free), 32'd1);
            chk({tag, " cpu pulse on ref edge"}, 32'(s_cpu_a), cvec(k >= 3 ? nc : oc));
            chk({tag, " cpu pulse mid cycle"}, 32'(s_cpu_b), cvec(k >= 2 ? nc : oc));
        end
    endtask

    // Wake from power-down or reset release: R2 (and R8 when PCI stop is low)
    task automatic wake_check(bit c, bit p, string tag);
        for (int k = 1; k <= S + 5; k++) begin
            step();
            chk({tag, " free"}, 32'(s_free), 32'(k >= S + 4));
            chk({tag, " pci group"}, 32'(s_pci), pvec(p && k >= S + 4));
            chk({tag, " cpu"}, 32'(s_cpu_b), cvec(c && k >= S + 3));
            chk({tag, " osc flag"}, 32'(s_osc), 32'(k < 3));
        end
    endtask

    initial begin
        bit cc, pp, nc, np;
        void'($urandom(32'h0005eed5));
        // R1: reset state
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R1 cpu", 32'(s_cpu_a | s_cpu_b), 32'd0);
            chk("R1 pci", 32'(s_pci), 32'd0);
            chk("R1 free", 32'(s_free), 32'd0);
            chk("R1 osc", 32'(s_osc), 32'd1);
        end
        @(negedge pci_clk); #2; rst_n = 1'b1;
        wake_check(1'b1, 1'b1, "R2 settle after reset");

        // Directed stops and restarts
        stop_change(1, 0, 1, 1, "R3 cpu stop");
        stop_change(0, 1, 1, 1, "R5 cpu restart");
        stop_change(1, 1, 1, 0, "R4 pci stop");
        stop_change(1, 1, 0, 1, "R5 pci restart");
        stop_change(1, 0, 1, 0, "R9 both stop");
        stop_change(0, 1, 0, 1, "R9 both restart");

        // Random toggles with random phase inside the low half-period
        cc = 1; pp = 1;
        for (int it = 0; it < 40; it++) begin
            nc = cc; np = pp;
            case ($urandom % 3)
                0: nc = ~cc;
                1: np = ~pp;
                default: begin nc = ~cc; np = ~pp; end
            endcase
            stop_change(cc, nc, pp, np, "R9 random");
            cc = nc; pp = np;
        end
        stop_change(cc, 1, pp, 1, "R5 restore");

        // R6: power down
        drive(1, 1, 0);
        for (int k = 1; k <= 6; k++) begin
            step();
            chk("R6 free", 32'(s_free), 32'(k < 4));
            chk("R6 pci group", 32'(s_pci), pvec(k < 4));
            chk("R6 cpu edge", 32'(s_cpu_a), cvec(k < 4));
            chk("R6 cpu mid", 32'(s_cpu_b), cvec(k < 3));
            chk("R6 osc flag", 32'(s_osc), 32'(k >= 3));
        end
        // PCI stop held low across the wake
        drive(1, 0, 0);
        repeat (3) step();
        drive(1, 0, 1);
        wake_check(1'b1, 1'b0, "R8 wake with pci stop");
        stop_change(1, 1, 0, 1, "R5 pci restart after wake");

        // R7: no clipped pulses anywhere in the run
        chk("R7 runt pulses", 32'(runts), 32'd0);
        chk("R7 pulses observed", 32'(pulses > 100), 32'd1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #2_000_000;
        n_chk++; n_err++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule